// File: doc/BRIEF.md
# Host interrupt status controller

The block gathers one-cycle event pulses from up to eighteen internal sources into a latched status word. It raises a single host interrupt line whenever an unmasked status bit is pending. Only fourteen of the eighteen positions are wired to sources. The remaining positions can never become set and always read as zero.

The host reaches the block through a simple register port with address, write strobe, read strobe and write data. Read data is combinational. It is presented in the same cycle as the read strobe.

The mask can be written as a whole, or changed bit by bit through separate set and clear addresses. Status can be read in two ways:
- a view that leaves the status unchanged;
- a view that returns the status and then empties it.

A write-only acknowledge address clears chosen status bits. A configuration register turns the interrupt pin on and picks its polarity.

Top module: `host_irq_ctrl`

Register addresses (`reg_addr`):

| Address | Access | Function |
|---|---|---|
| 0 | read/write | Mask register |
| 1 | write only | Mask set |
| 2 | write only | Mask clear |
| 3 | read only | Status, nondestructive view |
| 4 | read only | Status, clear-on-read view |
| 5 | write only | Acknowledge |
| 6 | read/write | Configuration |

## Requirements
- R1: After reset, the registers hold these values:
  - the mask reads 0x00001;
  - both status views read 0;
  - the configuration reads 0;
  - `host_irq` is 0.
- R2: The mask register at address 0 is read/write. A set mask bit keeps the matching status bit from raising the interrupt.
- R3: A write to address 1 sets every mask bit whose data bit is 1 and leaves all other mask bits unchanged.
- R4: A write to address 2 clears every mask bit whose data bit is 1 and leaves all other mask bits unchanged.
- R5: A read of address 3 returns the status and leaves it unchanged.
- R6: A read of address 4 returns the status as it was before the read. All status bits then clear at that clock edge, except any bit whose source pulses in the same cycle.
- R7: A write to address 5 clears every status bit whose data bit is 1, and the change shows in both status views. Zero data bits have no effect. A source pulse in the same cycle keeps its bit set.
- R8: Only the connected bit positions can become set. These are bits 0 to 10, bit 14, bit 16 and bit 17 (all connected bits set reads 0x347FF). All other status bits read as zero.
- R9: The configuration register at address 6 keeps bit 5 (interrupt enable) and bit 7 (active low); its other bits read as zero. When enable is 0, `host_irq` sits at the inactive level, which is the value of bit 7. When enable is 1, `host_irq` is the pending flag, inverted if bit 7 is 1.
- R10: A status bit becomes set in the cycle after its source pulses. It then stays set until it is acknowledged or cleared by a read. The pending flag is the OR of status ANDed with the inverted mask, registered, so it follows the status by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 18 | One-cycle event pulses from the interrupt sources |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the read-strobe cycle, 0 otherwise |
| host_irq | output | 1 | Host interrupt line |

## Verification
A source pulse can arrive in the same cycle in which the host empties the status, either through a clear-on-read access or through an acknowledge write. The bench forces both collisions:
- it pulses a source in the cycle of a clear-on-read read;
- it pulses a bit in the cycle of an acknowledge write that names that same bit.

The reference model makes the new event win. A follow-up nondestructive read, compared against the model, must show the colliding bit still pending while every other bit is cleared.

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl #(
  parameter int NSRC = 18,
  parameter int DW = 32,
  parameter int AW = 3,
  parameter logic [NSRC-1:0] IMPL = 18'h347FF,
  parameter logic [NSRC-1:0] MASK_RST = 18'h00001,
  parameter int EN_BIT = 5,
  parameter int LOW_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          host_irq
);
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_MSET = AW'(1);
  localparam logic [AW-1:0] A_MCLR = AW'(2);
  localparam logic [AW-1:0] A_VIEW = AW'(3);
  localparam logic [AW-1:0] A_COR  = AW'(4);
  localparam logic [AW-1:0] A_ACK  = AW'(5);
  localparam logic [AW-1:0] A_CFG  = AW'(6);

  logic [NSRC-1:0] mask_q, status_q, clr;
  logic cfg_en, cfg_low, irq_q;
  logic [NSRC-1:0] wbits;
  logic unused_wbits;

  assign wbits = reg_wdata[NSRC-1:0];
  assign unused_wbits = ^reg_wdata[DW-1:NSRC];

  always_comb begin
    clr = '0;
    if (reg_rd && reg_addr == A_COR) clr = '1;
    if (reg_wr && reg_addr == A_ACK) clr = clr | wbits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= MASK_RST;
      status_q <= '0;
      cfg_en   <= 1'b0;
      cfg_low  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_MASK: mask_q <= wbits;
          A_MSET: mask_q <= mask_q | wbits;
          A_MCLR: mask_q <= mask_q & ~wbits;
          A_CFG: begin
            cfg_en  <= reg_wdata[EN_BIT];
            cfg_low <= reg_wdata[LOW_BIT];
          end
          default: ;
        endcase
      end
      status_q <= (status_q & ~clr) | (src_pulse & IMPL);
      irq_q    <= |(status_q & ~mask_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_MASK: reg_rdata = DW'(mask_q);
        A_VIEW, A_COR: reg_rdata = DW'(status_q);
        A_CFG: begin
          reg_rdata[EN_BIT]  = cfg_en;
          reg_rdata[LOW_BIT] = cfg_low;
        end
        default: ;
      endcase
    end
  end

  assign host_irq = cfg_en ? (irq_q ^ cfg_low) : cfg_low;
endmodule

// File: rtl/host_irq_ctrl_chk.sv
module host_irq_ctrl_chk #(
  parameter int NSRC = 18,
  parameter int DW = 32,
  parameter int AW = 3,
  parameter logic [NSRC-1:0] IMPL = 18'h347FF
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_pulse,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [DW-1:0]   reg_wdata,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q
);
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse == '0 && !(reg_rd && reg_addr == AW'(4)) && !(reg_wr && reg_addr == AW'(5)))
    |=> status_q == $past(status_q));

  // R8
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~IMPL) == '0);

  // R6
  cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(4) && src_pulse == '0) |=> status_q == '0);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(5))
    |=> (status_q & $past(reg_wdata[NSRC-1:0] & ~src_pulse)) == '0);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0)
    |=> (status_q & $past(src_pulse & IMPL)) == $past(src_pulse & IMPL));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(1))
    |=> (mask_q & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0]));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(2))
    |=> (mask_q & $past(reg_wdata[NSRC-1:0])) == '0);
endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW), .IMPL(IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/host_irq_ctrl_tb.sv
`timescale 1ns/1ps
module host_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] src_pulse = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic host_irq;

  always #2.5 clk = ~clk;

  host_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [17:0] m_status, m_mask, wired;
  bit m_en, m_low, m_irq;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {14'd0, m_mask};
      3'd3, 3'd4: return {14'd0, m_status};
      3'd6: return (32'(m_en) << 5) | (32'(m_low) << 7);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd6: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic bit exp_irq();
    return m_en ? (m_irq ^ m_low) : m_low;
  endfunction

  task automatic model_reset();
    m_status = '0; m_mask = 18'h1; m_en = 0; m_low = 0; m_irq = 0;
  endtask

  task automatic cyc(input logic [17:0] s, input logic [2:0] a, input bit w, input bit r,
                     input logic [31:0] d);
    logic [17:0] clr;
    src_pulse = s; reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d;
    #1;
    check("R9", 32'(host_irq), 32'(exp_irq()));
    if (r) check(tag_of(a), reg_rdata, exp_rd(a));
    else check("R5", reg_rdata, 32'd0);
    @(posedge clk);
    clr = '0;
    if (r && a == 3'd4) clr = '1;
    if (w && a == 3'd5) clr = clr | d[17:0];
    m_irq = |(m_status & ~m_mask);
    if (w) begin
      case (a)
        3'd0: m_mask = d[17:0];
        3'd1: m_mask = m_mask | d[17:0];
        3'd2: m_mask = m_mask & ~d[17:0];
        3'd6: begin m_en = d[5]; m_low = d[7]; end
        default: ;
      endcase
    end
    m_status = (m_status & ~clr) | (s & wired);
    @(negedge clk);
    src_pulse = '0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 3'd0, 0, 0, 0);
  endtask

  initial begin
    wired = '0;
    for (int b = 0; b <= 10; b++) wired[b] = 1'b1;
    wired[14] = 1'b1; wired[16] = 1'b1; wired[17] = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_addr = 3'd0; reg_rd = 1; #1;
    check("R1", reg_rdata, 32'h1);
    check("R1", 32'(host_irq), 32'd0);
    @(negedge clk); reg_rd = 0;
    cyc('0, 3'd3, 0, 1, 0);
    cyc('0, 3'd6, 0, 1, 0);

    // R9 enable, R10 latch
    cyc('0, 3'd6, 1, 0, 32'h20);
    cyc('0, 3'd6, 0, 1, 0);
    cyc(18'h2, 3'd0, 0, 0, 0);
    idle(3);
    cyc('0, 3'd3, 0, 1, 0);
    cyc('0, 3'd3, 0, 1, 0);
    // R7 ack
    cyc('0, 3'd5, 1, 0, 32'h2);
    idle(2);
    // R2 masked bit 0
    cyc(18'h1, 3'd0, 0, 0, 0);
    idle(2);
    cyc('0, 3'd0, 1, 0, 32'h0);
    idle(2);
    cyc('0, 3'd0, 0, 1, 0);
    cyc('0, 3'd0, 1, 0, 32'h3FFFF);
    idle(2);
    // R3 / R4 mask set and clear
    cyc('0, 3'd2, 1, 0, 32'h00F0F);
    cyc('0, 3'd0, 0, 1, 0);
    cyc('0, 3'd1, 1, 0, 32'h00003);
    cyc('0, 3'd0, 0, 1, 0);
    cyc('0, 3'd2, 1, 0, 32'h20001);
    cyc('0, 3'd0, 0, 1, 0);
    idle(2);
    // R8 all sources pulse
    cyc('1, 3'd0, 0, 0, 0);
    reg_addr = 3'd3; reg_rd = 1; #1;
    check("R8", reg_rdata, 32'h347FF);
    @(negedge clk); reg_rd = 0;
    idle(2);
    // R6 clear-on-read colliding with event on bit 4
    cyc(18'h10, 3'd4, 0, 1, 0);
    cyc('0, 3'd3, 0, 1, 0);
    reg_addr = 3'd3; reg_rd = 1; #1;
    check("R6", reg_rdata, 32'h10);
    @(negedge clk); reg_rd = 0;
    // R7 ack colliding with event on same bit
    cyc(18'h1C0, 3'd0, 0, 0, 0);
    cyc(18'h040, 3'd5, 1, 0, 32'h0C0);
    cyc('0, 3'd3, 0, 1, 0);
    cyc('0, 3'd5, 1, 0, 32'h3FFFF);
    cyc('0, 3'd4, 0, 1, 0);
    // R9 polarity and disable
    cyc('0, 3'd0, 1, 0, 32'h0);
    cyc(18'h400, 3'd6, 1, 0, 32'hA0);
    idle(3);
    cyc('0, 3'd6, 0, 1, 0);
    cyc('0, 3'd6, 1, 0, 32'h80);
    idle(2);
    cyc('0, 3'd6, 1, 0, 32'hFFFF_FF5F);
    cyc('0, 3'd6, 0, 1, 0);
    cyc('0, 3'd4, 0, 1, 0);
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule